// File: doc/BRIEF.md
# Microwire serial EEPROM command engine

This block is a master for single transactions on a four-wire serial EEPROM link. The four wires are chip select, shift clock, data to the memory and data from the memory. A host places a command word and a bit count on its inputs and pulses `start`. The engine drives the bits out most significant first and samples the returned line once per bit. When it finishes it presents the captured word and pulses `done`. Command formats carry the start bit as the top bit of a 3-bit opcode: read `110`, write `101`, erase `111`. A read or write frame is 3 + A + 16 bits long, where A is the address width. The write-enable and write-disable frames place a pattern in the address field and are 3 + A bits long. The engine treats every frame as plain bits, so the host builds all of these formats.

The second operation is a ready poll. The host starts it with `poll_mode` high. Chip select rises and the shift clock stays low. The engine samples the returned line once per half-period until it reads 1 or until a fixed number of samples have been taken. It then reports how many samples read 0 and whether it gave up.

Top module: `mw_cmd_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mw_cs`, `mw_sk`, `mw_di`, `busy`, `done`, `poll_timeout`, `rdata` and `poll_count` are all 0.
- R2: A command of `cmd_len` bits sends `cmd_word[cmd_len-1]` first and `cmd_word[0]` last. Each bit is held on `mw_di` for HALF_CYC cycles with `mw_sk` low and then for HALF_CYC cycles with `mw_sk` high. The first low half begins on the cycle after the clock edge that accepts `start`.
- R3: `mw_do` is sampled on the last cycle of each high half and enters the capture word at its LSB. On `done`, `rdata` holds the `cmd_len` returned bits right-aligned, with the first returned bit highest and the bits above `cmd_len` equal to 0.
- R4: `mw_cs` is high from the first cycle of a frame or poll through its last cycle. It is low on the `done` cycle. Whenever `busy` is low, `mw_cs`, `mw_sk` and `mw_di` are low.
- R5: For a command, `busy` is high for exactly 2·HALF_CYC·`cmd_len` cycles. `done` is a one-cycle pulse on the first cycle after that, with `busy` low.
- R6: A `start` that arrives while `busy` is high is ignored. A change of `cmd_word` or `poll_mode` during a frame is also ignored, so the frame in progress goes on unchanged.
- R7: During a poll, `mw_sk` and `mw_di` stay low and `mw_do` is sampled every HALF_CYC cycles. The poll ends at the first sample that reads 1, taken HALF_CYC·(N+1) cycles after start. On `done`, `poll_count` equals N, the number of samples that read 0, and `poll_timeout` is 0.
- R8: If POLL_LIMIT samples all read 0, the poll ends after HALF_CYC·POLL_LIMIT busy cycles. `poll_count` is then POLL_LIMIT and `poll_timeout` is 1.
- R9: The shortest length (1 bit) and the longest length (MAX_LEN = 27 bits) follow R2 and R3 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; taken only while idle |
| poll_mode | input | 1 | 0 = shift a command, 1 = ready poll |
| cmd_word | input | MAX_LEN | Command bits, right-aligned |
| cmd_len | input | $clog2(MAX_LEN+1) | Number of bits to send, 1..MAX_LEN |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | MAX_LEN | Captured returned bits of the last command |
| poll_count | output | $clog2(POLL_LIMIT+1) | Zero samples seen by the last poll |
| poll_timeout | output | 1 | Last poll gave up |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Shift clock to the memory |
| mw_di | output | 1 | Serial data to the memory |
| mw_do | input | 1 | Serial data from the memory |

## Verification
The assertions take `cmd_len` to lie between 1 and MAX_LEN whenever `start` is high. They also take `mw_do` to behave like a memory that changes its output only after a shift-clock rise, or at a moment the host chooses during a poll. The stimulus uses only lengths inside that range, including both ends. The bench's memory model presents the next response bit only when it sees `mw_sk` rise, and it raises the poll line between two sampling points. Start pulses that arrive mid-frame carry deliberately different command words and mode. This shows that the latched frame, and not the live inputs, drives the link.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_POLL = 2'd3
  } mw_state_e;
endpackage

// File: rtl/mw_tick_gen.sv
// Half-period pacing: pulses once every HALF_CYC enabled cycles.
module mw_tick_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/mw_capture.sv
// Returned-bit shift register; only W-1 bits need storing because at most
// W shifts happen between clears and the newest bit arrives on din.
module mw_capture #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic [W-2:0] q;

  assign nxt = {q, din};

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (shift) q <= nxt[W-2:0];
  end
endmodule

// File: rtl/mw_poll_ctr.sv
// Counts ready-poll samples that read 0; flags the final allowed sample.
module mw_poll_ctr #(
  parameter int LIMIT = 10000,
  parameter int CW    = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);
  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/mw_cmd_engine.sv
module mw_cmd_engine
  import mw_pkg::*;
#(
  parameter int HALF_CYC   = 4,
  parameter int MAX_LEN    = 27,
  parameter int POLL_LIMIT = 10000,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int PC_W      = $clog2(POLL_LIMIT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               poll_mode,
  input  logic [MAX_LEN-1:0] cmd_word,
  input  logic [LEN_W-1:0]   cmd_len,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] rdata,
  output logic [PC_W-1:0]    poll_count,
  output logic               poll_timeout,
  output logic               mw_cs,
  output logic               mw_sk,
  output logic               mw_di,
  input  logic               mw_do
);
  mw_state_e          state;
  logic [MAX_LEN-1:0] cmd_q;
  logic [LEN_W-1:0]   bidx;
  logic               tick;
  logic               accept;
  logic               cap_shift;
  logic [MAX_LEN-1:0] cap_nxt;
  logic [PC_W-1:0]    pcnt;
  logic               plast;
  logic               pinc;

  assign accept    = (state == ST_IDLE) && start;
  assign cap_shift = (state == ST_HIGH) && tick;
  assign pinc      = (state == ST_POLL) && tick && !mw_do && !plast;

  mw_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (state != ST_IDLE),
    .tick (tick)
  );

  mw_capture #(.W(MAX_LEN)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .shift (cap_shift),
    .din   (mw_do),
    .nxt   (cap_nxt)
  );

  mw_poll_ctr #(.LIMIT(POLL_LIMIT), .CW(PC_W)) u_pctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .inc  (pinc),
    .cnt  (pcnt),
    .last (plast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cmd_q        <= '0;
      bidx         <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      rdata        <= '0;
      poll_count   <= '0;
      poll_timeout <= 1'b0;
      mw_cs        <= 1'b0;
      mw_sk        <= 1'b0;
      mw_di        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy  <= 1'b1;
            mw_cs <= 1'b1;
            mw_sk <= 1'b0;
            if (poll_mode) begin
              state <= ST_POLL;
              mw_di <= 1'b0;
            end else begin
              state <= ST_LOW;
              cmd_q <= cmd_word;
              bidx  <= cmd_len - LEN_W'(1);
              mw_di <= cmd_word[cmd_len - LEN_W'(1)];
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            state <= ST_HIGH;
            mw_sk <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (bidx == '0) begin
              state <= ST_IDLE;
              rdata <= cap_nxt;
              busy  <= 1'b0;
              done  <= 1'b1;
              mw_cs <= 1'b0;
              mw_sk <= 1'b0;
              mw_di <= 1'b0;
            end else begin
              state <= ST_LOW;
              mw_sk <= 1'b0;
              bidx  <= bidx - LEN_W'(1);
              mw_di <= cmd_q[bidx - LEN_W'(1)];
            end
          end
        end
        ST_POLL: begin
          if (tick && (mw_do || plast)) begin
            state        <= ST_IDLE;
            busy         <= 1'b0;
            done         <= 1'b1;
            mw_cs        <= 1'b0;
            poll_timeout <= !mw_do;
            poll_count   <= mw_do ? pcnt : PC_W'(POLL_LIMIT);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_cmd_engine_chk.sv
module mw_cmd_engine_chk #(
  parameter int POLL_LIMIT = 10000,
  parameter int PC_W       = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [PC_W-1:0] poll_count,
  input logic            poll_timeout,
  input logic            mw_cs,
  input logic            mw_sk,
  input logic            mw_di
);
  assert_idle_lines_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mw_cs && !mw_sk && !mw_di));

  assert_clock_needs_select_R4: assert property (@(posedge clk) disable iff (rst)
    mw_sk |-> mw_cs);

  assert_data_steady_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mw_sk) |-> $stable(mw_di));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_busy_only_from_idle_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && !$past(busy)));

  assert_timeout_count_R8: assert property (@(posedge clk) disable iff (rst)
    (done && poll_timeout) |-> (poll_count == PC_W'(POLL_LIMIT)));
endmodule

bind mw_cmd_engine mw_cmd_engine_chk #(
  .POLL_LIMIT (POLL_LIMIT),
  .PC_W       (PC_W)
) u_mw_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .poll_count   (poll_count),
  .poll_timeout (poll_timeout),
  .mw_cs        (mw_cs),
  .mw_sk        (mw_sk),
  .mw_di        (mw_di)
);

// File: tb/test_mw_cmd_engine.sv
module test_mw_cmd_engine;
  localparam int H     = 2;
  localparam int ML    = 27;
  localparam int LIMIT = 10000;

  typedef struct packed {
    logic cs, sk, di, busy, done, chk_rd, chk_poll;
    logic [26:0] rd;
    logic [13:0] pc;
    logic to;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        poll_mode = 1'b0;
  logic [26:0] cmd_word = '0;
  logic [4:0]  cmd_len = 5'd1;
  logic        busy, done, poll_timeout, mw_cs, mw_sk, mw_di, mw_do;
  logic [26:0] rdata;
  logic [13:0] poll_count;

  int    vectors = 0;
  int    miscompares = 0;
  bit    chk_en = 1'b0;
  string cur_req = "R1";
  exp_t  exp_q[$];

  // memory model
  logic        use_poll = 1'b0;
  logic        poll_line = 1'b0;
  logic [26:0] resp_word = '0;
  int          resp_len = 1;
  int          sk_rises = 0;

  always #10 clk = ~clk;

  always @(posedge mw_sk) sk_rises = sk_rises + 1;

  assign mw_do = use_poll ? poll_line :
                 ((sk_rises > 0 && sk_rises <= resp_len) ? resp_word[resp_len - sk_rises] : 1'b0);

  mw_cmd_engine #(.HALF_CYC(H), .MAX_LEN(ML), .POLL_LIMIT(LIMIT)) i_mw_cmd_engine (
    .clk(clk), .rst(rst), .start(start), .poll_mode(poll_mode),
    .cmd_word(cmd_word), .cmd_len(cmd_len), .busy(busy), .done(done),
    .rdata(rdata), .poll_count(poll_count), .poll_timeout(poll_timeout),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
  );

  task automatic miss(input string what, input string req, input logic [31:0] act, input logic [31:0] expv);
    miscompares++;
    $display("FAIL %s %s (test %s): actual %0h expected %0h at %0t", req, what, cur_req, act, expv, $time);
  endtask

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (chk_en) begin
      exp_t e;
      e = '0;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      vectors++;
      if (mw_cs !== e.cs)   miss("mw_cs", rst ? "R1" : "R4", 32'(mw_cs), 32'(e.cs));
      if (mw_sk !== e.sk)   miss("mw_sk", rst ? "R1" : "R2", 32'(mw_sk), 32'(e.sk));
      if (mw_di !== e.di)   miss("mw_di", rst ? "R1" : "R2", 32'(mw_di), 32'(e.di));
      if (busy !== e.busy)  miss("busy",  rst ? "R1" : "R5", 32'(busy), 32'(e.busy));
      if (done !== e.done)  miss("done",  rst ? "R1" : "R5", 32'(done), 32'(e.done));
      if (e.chk_rd && rdata !== e.rd) miss("rdata", "R3", 32'(rdata), 32'(e.rd));
      if (e.chk_poll && poll_count !== e.pc) miss("poll_count", "R7", 32'(poll_count), 32'(e.pc));
      if (e.chk_poll && poll_timeout !== e.to) miss("poll_timeout", "R8", 32'(poll_timeout), 32'(e.to));
    end
  end

  task automatic push_n(input int n, input logic sk, input logic di);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e = '0;
      e.cs = 1'b1; e.sk = sk; e.di = di; e.busy = 1'b1;
      exp_q.push_back(e);
    end
  endtask

  // Shift one command; optional intruding start at cycle poke_at (R6).
  task automatic run_cmd(input logic [26:0] cmd, input int len, input logic [26:0] resp, input int poke_at);
    exp_t e;
    logic [26:0] mask;
    int total;
    mask = (len == 27) ? 27'h7FFFFFF : ((27'd1 << len) - 27'd1);
    @(negedge clk); #2;
    use_poll = 1'b0; resp_word = resp; resp_len = len; sk_rises = 0;
    cmd_word = cmd; cmd_len = 5'(len); poll_mode = 1'b0; start = 1'b1;
    for (int j = 0; j < len; j++) begin
      push_n(H, 1'b0, cmd[len-1-j]);
      push_n(H, 1'b1, cmd[len-1-j]);
    end
    e = '0; e.done = 1'b1; e.chk_rd = 1'b1; e.rd = resp & mask;
    exp_q.push_back(e);
    total = 2 * H * len + 1;
    @(negedge clk); #2 start = 1'b0;
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      #2 start = 1'b1; cmd_word = ~cmd; poll_mode = 1'b1;
      @(negedge clk); #2 start = 1'b0; poll_mode = 1'b0;
      repeat (total - poke_at - 1) @(negedge clk);
    end else begin
      repeat (total) @(negedge clk);
    end
  endtask

  // Ready poll: line rises so that sample n is the first to read 1, or never.
  task automatic run_poll(input int n, input bit give_up);
    exp_t e;
    int busy_cycles;
    int total;
    busy_cycles = give_up ? LIMIT * H : (n + 1) * H;
    @(negedge clk); #2;
    use_poll = 1'b1; poll_line = 1'b0; poll_mode = 1'b1; start = 1'b1;
    push_n(busy_cycles, 1'b0, 1'b0);
    e = '0; e.done = 1'b1; e.chk_poll = 1'b1;
    e.pc = give_up ? 14'(LIMIT) : 14'(n); e.to = give_up;
    exp_q.push_back(e);
    total = busy_cycles + 1;
    @(negedge clk); #2 start = 1'b0; poll_mode = 1'b0;
    if (!give_up) begin
      repeat (n * H) @(negedge clk);
      #2 poll_line = 1'b1;
      repeat (total - n * H) @(negedge clk);
    end else begin
      repeat (total) @(negedge clk);
    end
    #2 poll_line = 1'b0; use_poll = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    miscompares++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state, checked on every cycle while rst is high
    @(posedge clk); @(negedge clk);
    chk_en = 1'b1;
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (rdata !== '0 || poll_count !== '0 || poll_timeout !== 1'b0)
      miss("reset regs", "R1", 32'(rdata) ^ 32'(poll_count), 32'd0);

    cur_req = "R2 read";
    run_cmd({3'b110, 6'd5, 16'h0}, 25, 25'h0ABCD, 0);
    cur_req = "R2 write-enable";
    run_cmd(27'(7'b1001111 << 2), 9, 27'h155, 0);
    cur_req = "R3 write";
    run_cmd({3'b101, 6'd33, 16'hBEEF}, 25, 25'h1FFFFFF, 0);
    cur_req = "R9 max length";
    run_cmd(27'h5A5A5A5, 27, 27'h6C3F0A1, 0);
    cur_req = "R9 single bit";
    run_cmd(27'h1, 1, 27'h1, 0);
    run_cmd(27'h0, 1, 27'h0, 0);
    cur_req = "R6 start while busy";
    run_cmd({3'b111, 8'hC3}, 11, 27'h2A5, 5);
    run_cmd(27'(7'b1000000 << 4), 11, 27'h7FF, 30);
    cur_req = "R7 poll immediate";
    run_poll(0, 1'b0);
    cur_req = "R7 poll after 5";
    run_poll(5, 1'b0);
    cur_req = "R3 rdata after poll";
    run_cmd({3'b110, 8'h01, 16'h0}, 27, 27'h0001234, 0);
    cur_req = "R8 poll timeout";
    run_poll(0, 1'b1);
    cur_req = "R7 poll after timeout";
    run_poll(37, 1'b0);
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule